// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Checks

This block holds a small set of recently used page-table entries and turns a virtual address into a physical address within the cycle in which the lookup is presented. Each entry carries a virtual page tag, a physical page number, a page-present flag and three permission flags. A lookup of a given access type ends in exactly one of four outcomes: a translation, a miss, a protection fault or a page fault. Pages are 8 KB, so the 13 offset bits pass through untranslated. With the default 32-bit addresses, the tag is 19 bits wide.

An external table walker answers misses through the refill port. A refill goes into the lowest empty slot. When no slot is empty, it replaces the least recently used slot. A flush input empties every slot at once.

The lookup result is classified into one of five named outcomes:
- OUT_IDLE: no lookup is presented.
- OUT_MISS: no slot matches.
- OUT_PAGE: the matching slot is marked not present.
- OUT_PROT: the matching slot forbids the access type.
- OUT_HIT: the lookup is translated.

Each outcome drives its own output flag through a unique case.

Top module: `tlb_xlate`

## Requirements
- R1: On a translated lookup, `lk_pa` equals the slot's physical page number followed by the 13 low bits of `lk_va` unchanged, in the same cycle.
- R2: A lookup whose page number matches no slot with its tag-valid bit set raises `lk_miss` in the same cycle. A slot at any index can match.
- R3: If the matching slot has its present bit clear, the lookup raises `lk_page_fault` only, with `lk_hit` low and `lk_pa` zero.
- R4: Permission bit 0 grants read, bit 1 grants write and bit 2 grants execute. `lk_acc` encodes 0 = read, 1 = write, 2 = execute, and 3 is reserved and never permitted. A present, matching slot that lacks the requested right raises `lk_prot_fault` only.
- R5: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss`, `lk_prot_fault`, `lk_page_fault` is high. While it is low, all four are low. `lk_pa` is zero except on a hit.
- R6: A refill takes effect from the next rising clock edge. A lookup in the refill cycle sees the old contents.
- R7: A flush empties every slot from the next edge. A refill presented in the same cycle as a flush is dropped.
- R8: A refill goes into the lowest-indexed empty slot. If no slot is empty, it replaces the least recently used slot. A slot counts as used when it is refilled or when it translates a lookup. When a refill and a translation occur in the same cycle, only the refill counts.
- R9: If two slots hold the same page number, the lower-indexed slot supplies the result.
- R10: After one miss and one refill, all 1024 sequential eight-byte accesses within that page hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup presented |
| lk_va | input | VA_W | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| fill_en | input | 1 | Install an entry at the next edge |
| fill_vpn | input | VA_W-PAGE_BITS | Virtual page number of the new entry |
| fill_ppn | input | PA_W-PAGE_BITS | Physical page number of the new entry |
| fill_present | input | 1 | Page resident in memory |
| fill_perm | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Empty all slots at the next edge |
| lk_hit | output | 1 | Lookup translated |
| lk_pa | output | PA_W | Physical address, zero unless hit |
| lk_miss | output | 1 | No matching slot |
| lk_prot_fault | output | 1 | Access type not permitted |
| lk_page_fault | output | 1 | Matching page not resident |

## Verification
The bench builds the block with ENTRIES = 4 and keeps the 32-bit addresses and 13-bit page offset. With only four slots, the replacement order is reachable in a handful of refills: the empty-slot preference, eviction of the least recently used slot after a hit reorders use, and the effect of duplicates. The full-width page offset keeps the 1024-access sequential walk within a single page, as the requirement describes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        OUT_IDLE,
        OUT_MISS,
        OUT_PAGE,
        OUT_PROT,
        OUT_HIT
    } outcome_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
    localparam int PERM_BITS = 3;
endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [1:0]           acc,
    input  logic [PERM_BITS-1:0] perm,
    output logic                 allow
);
    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  allow = perm[PERM_R];
            ACC_WRITE: allow = perm[PERM_W];
            ACC_EXEC:  allow = perm[PERM_X];
            ACC_RSVD:  allow = 1'b0;
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 128,
    parameter int VPN_W   = 19,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [VPN_W-1:0]                vpn,
    input  logic [ENTRIES-1:0]              tag_vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   tags,
    output logic                            match_any,
    output logic [IDX_W-1:0]                match_idx
);
    logic [ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = tag_vld[g] && (tags[g] == vpn);
    end

    always_comb begin
        match_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end

    assign match_any = |match_vec;

    AST_MATCH_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        match_any |-> (tag_vld[match_idx] && tags[match_idx] == vpn)); // R2

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        match_any |-> ((match_vec & ((ENTRIES'(1) << match_idx) - ENTRIES'(1))) == '0)); // R9
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] occupied,
    output logic [IDX_W-1:0]   victim_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] rank;
    logic [ENTRIES-1:0]            oldest_oh;
    logic [IDX_W-1:0]              oldest_idx;
    logic [IDX_W-1:0]              empty_idx;
    logic                          any_empty;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        assign oldest_oh[g] = (rank[g] == OLDEST);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rank[g] <= IDX_W'(g);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(g))
                    rank[g] <= '0;
                else if (rank[g] < rank[touch_idx])
                    rank[g] <= rank[g] + 1'b1;
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        empty_idx  = '0;
        any_empty  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (oldest_oh[i]) oldest_idx = IDX_W'(i);
            if (!occupied[i]) begin
                empty_idx = IDX_W'(i);
                any_empty = 1'b1;
            end
        end
        victim_idx = any_empty ? empty_idx : oldest_idx;
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_oh)); // R8

    AST_TOUCH_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> !oldest_oh[$past(touch_idx)]); // R8
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 13,
    parameter int ENTRIES   = 128,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic [1:0]       lk_acc,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_present,
    input  logic [2:0]       fill_perm,
    input  logic             flush,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_pa,
    output logic             lk_miss,
    output logic             lk_prot_fault,
    output logic             lk_page_fault
);
    logic [ENTRIES-1:0]                  tag_vld;
    logic [ENTRIES-1:0][VPN_W-1:0]       tags;
    logic [ENTRIES-1:0][PPN_W-1:0]       ppns;
    logic [ENTRIES-1:0]                  present;
    logic [ENTRIES-1:0][PERM_BITS-1:0]   perms;

    logic             match_any;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] victim_idx;
    logic             allow;
    logic             do_fill;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    outcome_e         outcome;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .vpn       (lk_va[VA_W-1:PAGE_BITS]),
        .tag_vld   (tag_vld),
        .tags      (tags),
        .match_any (match_any),
        .match_idx (match_idx)
    );

    tlb_perm u_perm (
        .acc   (lk_acc),
        .perm  (perms[match_idx]),
        .allow (allow)
    );

    assign do_fill   = fill_en && !flush;
    assign touch_en  = do_fill || (outcome == OUT_HIT);
    assign touch_idx = do_fill ? victim_idx : match_idx;

    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .occupied   (tag_vld),
        .victim_idx (victim_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_vld <= '0;
            tags    <= '0;
            ppns    <= '0;
            present <= '0;
            perms   <= '0;
        end else if (flush) begin
            tag_vld <= '0;
        end else if (fill_en) begin
            tag_vld[victim_idx] <= 1'b1;
            tags[victim_idx]    <= fill_vpn;
            ppns[victim_idx]    <= fill_ppn;
            present[victim_idx] <= fill_present;
            perms[victim_idx]   <= fill_perm;
        end
    end

    always_comb begin
        if (!lk_valid)              outcome = OUT_IDLE;
        else if (!match_any)        outcome = OUT_MISS;
        else if (!present[match_idx]) outcome = OUT_PAGE;
        else if (!allow)            outcome = OUT_PROT;
        else                        outcome = OUT_HIT;
    end

    always_comb begin
        lk_hit        = 1'b0;
        lk_miss       = 1'b0;
        lk_prot_fault = 1'b0;
        lk_page_fault = 1'b0;
        lk_pa         = '0;
        unique case (outcome)
            OUT_IDLE: ;
            OUT_MISS: lk_miss = 1'b1;
            OUT_PAGE: lk_page_fault = 1'b1;
            OUT_PROT: lk_prot_fault = 1'b1;
            OUT_HIT: begin
                lk_hit = 1'b1;
                lk_pa  = {ppns[match_idx], lk_va[PAGE_BITS-1:0]};
            end
            default: ;
        endcase
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_prot_fault, lk_page_fault}) == 1); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_prot_fault || lk_page_fault)); // R5

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[PAGE_BITS-1:0] == lk_va[PAGE_BITS-1:0]); // R1

    AST_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_pa == '0); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !(lk_valid && !lk_miss)); // R7

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> tag_vld[$past(victim_idx)]); // R6
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int PB    = 13;
    localparam int VPN_W = VA_W - PB;
    localparam int PPN_W = PA_W - PB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [VA_W-1:0] lk_va = '0;
    logic [1:0] lk_acc = '0;
    logic fill_en = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic fill_present = 1'b0;
    logic [2:0] fill_perm = '0;
    logic flush = 1'b0;
    logic lk_hit, lk_miss, lk_prot_fault, lk_page_fault;
    logic [PA_W-1:0] lk_pa;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB), .ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_acc(lk_acc),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_present(fill_present), .fill_perm(fill_perm), .flush(flush),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_miss(lk_miss),
        .lk_prot_fault(lk_prot_fault), .lk_page_fault(lk_page_fault)
    );

    // Outcome code: 0 idle, 1 miss, 2 page fault, 3 protection fault, 4 hit
    function automatic logic [3:0] flags_of(input int code);
        case (code)
            1: return 4'b0100;
            2: return 4'b0001;
            3: return 4'b0010;
            4: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int grade(input logic pres, input logic [2:0] perm, input logic [1:0] acc);
        if (!pres) return 2;
        if (acc == 2'd3) return 3;
        return perm[acc] ? 4 : 3;
    endfunction

    // Drive every input at the falling edge, then let the combinational outputs settle.
    task automatic drive(input logic lv, input logic [VA_W-1:0] va, input logic [1:0] acc,
                         input logic fe, input logic [VPN_W-1:0] fv, input logic [PPN_W-1:0] fp,
                         input logic fpres, input logic [2:0] fperm, input logic fl);
        @(negedge clk);
        lk_valid = lv; lk_va = va; lk_acc = acc;
        fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_present = fpres; fill_perm = fperm;
        flush = fl;
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input string req, input int code, input logic [PA_W-1:0] pa);
        logic [3:0] got, exp;
        got = {lk_hit, lk_miss, lk_prot_fault, lk_page_fault};
        exp = flags_of(code);
        checks++;
        if (got !== exp || lk_pa !== pa) begin
            failures++;
            $display("FAIL %s flags(h,m,p,f)=%b pa=%h expected flags=%b pa=%h", req, got, lk_pa, exp, pa);
        end
    endtask

    task automatic look(input logic [VPN_W-1:0] vpn, input logic [PB-1:0] off, input logic [1:0] acc);
        drive(1'b1, {vpn, off}, acc, 1'b0, '0, '0, 1'b0, 3'b0, 1'b0);
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic pres, input logic [2:0] perm);
        drive(1'b0, '0, 2'd0, 1'b1, vpn, ppn, pres, perm, 1'b0);
    endtask

    function automatic logic [PA_W-1:0] pa_of(input logic [PPN_W-1:0] ppn, input logic [PB-1:0] off);
        return {ppn, off};
    endfunction

    localparam logic [VPN_W-1:0] VA_A = 19'h00010, VA_B = 19'h00020, VA_C = 19'h00030,
                                 VA_D = 19'h00040, VA_E = 19'h00050, VA_F = 19'h00060,
                                 VA_G = 19'h00070;
    localparam logic [PPN_W-1:0] PP_A = 19'h0ABCD, PP_B = 19'h01111, PP_C = 19'h02222,
                                 PP_D = 19'h03333, PP_E = 19'h04444, PP_F = 19'h05555;

    logic [VPN_W-1:0] rv [N];
    logic [PPN_W-1:0] rp [N];
    logic             rpres [N];
    logic [2:0]       rperm [N];

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // Reset state
        look(VA_A, 13'h0, 2'd0);   check("R2 reset miss", 1, '0);
        drive(1'b0, '0, 2'd0, 1'b0, '0, '0, 1'b0, 3'b0, 1'b0);
        check("R5 idle quiet", 0, '0);

        // Refill with a same-cycle lookup of the same page: old contents seen
        drive(1'b1, {VA_A, 13'h123}, 2'd0, 1'b1, VA_A, PP_A, 1'b1, 3'b011, 1'b0);
        check("R6 same-cycle miss", 1, '0);
        look(VA_A, 13'h123, 2'd0); check("R1 read hit", 4, pa_of(PP_A, 13'h123));
        look(VA_A, 13'h1FFF, 2'd1); check("R1 write hit", 4, pa_of(PP_A, 13'h1FFF));
        look(VA_A, 13'h0, 2'd2);   check("R4 exec denied", 3, '0);
        look(VA_A, 13'h0, 2'd3);   check("R4 reserved denied", 3, '0);

        fill(VA_B, PP_B, 1'b0, 3'b111);
        look(VA_B, 13'h40, 2'd0);  check("R3 not present", 2, '0);
        fill(VA_C, PP_C, 1'b1, 3'b100);
        look(VA_C, 13'h8, 2'd0);   check("R4 exec-only read", 3, '0);
        look(VA_C, 13'h8, 2'd2);   check("R4 exec-only exec", 4, pa_of(PP_C, 13'h8));
        fill(VA_D, PP_D, 1'b1, 3'b001);
        look(VA_D, 13'h10, 2'd1);  check("R4 read-only write", 3, '0);

        // Replacement: A is oldest, touch it so B becomes the victim
        look(VA_A, 13'h0, 2'd0);   check("R8 touch A", 4, pa_of(PP_A, 13'h0));
        fill(VA_E, PP_E, 1'b1, 3'b011);
        look(VA_B, 13'h0, 2'd0);   check("R8 B evicted", 1, '0);
        look(VA_A, 13'h4, 2'd0);   check("R8 A kept", 4, pa_of(PP_A, 13'h4));
        look(VA_E, 13'h4, 2'd0);   check("R8 E installed", 4, pa_of(PP_E, 13'h4));
        fill(VA_F, PP_F, 1'b1, 3'b011);
        look(VA_C, 13'h0, 2'd2);   check("R8 C evicted", 1, '0);
        look(VA_D, 13'h0, 2'd0);   check("R8 D kept", 4, pa_of(PP_D, 13'h0));
        look(VA_F, 13'h0, 2'd0);   check("R8 F installed", 4, pa_of(PP_F, 13'h0));

        // Flush beats a same-cycle refill
        drive(1'b0, '0, 2'd0, 1'b1, VA_G, PP_A, 1'b1, 3'b111, 1'b1);
        look(VA_A, 13'h0, 2'd0);   check("R7 A flushed", 1, '0);
        look(VA_D, 13'h0, 2'd0);   check("R7 D flushed", 1, '0);
        look(VA_G, 13'h0, 2'd0);   check("R7 fill dropped", 1, '0);

        // Duplicate tags: lower slot supplies the result
        fill(VA_G, PP_B, 1'b1, 3'b111);
        fill(VA_G, PP_C, 1'b1, 3'b111);
        look(VA_G, 13'h55, 2'd0);  check("R9 lowest slot", 4, pa_of(PP_B, 13'h55));

        // Sequential walk through one page
        drive(1'b0, '0, 2'd0, 1'b0, '0, '0, 1'b0, 3'b0, 1'b1);
        look(19'h12345, 13'h0, 2'd0); check("R10 first miss", 1, '0);
        fill(19'h12345, 19'h0F0F0, 1'b1, 3'b001);
        for (int k = 0; k < 1024; k++) begin
            look(19'h12345, 13'(k * 8), 2'd0);
            check("R10 walk hit", 4, pa_of(19'h0F0F0, 13'(k * 8)));
        end

        // Random lookups over a filled buffer
        drive(1'b0, '0, 2'd0, 1'b0, '0, '0, 1'b0, 3'b0, 1'b1);
        for (int i = 0; i < N; i++) begin
            rv[i] = {1'b0, 14'($urandom()), 4'(i)};
            rp[i] = 19'($urandom());
            rpres[i] = ($urandom() % 4) != 0;
            rperm[i] = 3'($urandom());
            fill(rv[i], rp[i], rpres[i], rperm[i]);
        end
        for (int t = 0; t < 400; t++) begin
            int sel;
            logic [1:0] acc;
            logic [PB-1:0] off;
            sel = int'($urandom() % (N + 2));
            acc = 2'($urandom());
            off = 13'($urandom());
            if (sel < N) begin
                int code;
                look(rv[sel], off, acc);
                code = grade(rpres[sel], rperm[sel], acc);
                check("R4 random", code, code == 4 ? pa_of(rp[sel], off) : '0);
            end else begin
                look({1'b1, 18'($urandom())}, off, acc);
                check("R2 random miss", 1, '0);
            end
        end

        drive(1'b0, '0, 2'd0, 1'b0, '0, '0, 1'b0, 3'b0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule